// File: doc/BRIEF.md
# Key-Sequenced Command Controller

This block sits behind a serial frame receiver and reads the register writes it delivers. Three kinds of write are special. Writes to the key register run an ordered two-key software reset and a calibration-memory refresh command. Writes to the load register produce a load strobe for the output latches. Writes to the diagnostic register clear sticky flags: a 1 written to a bit clears that bit.

Each write carries a device address. It is compared with the device's strap pins. A write whose device address does not match is dropped. The one exception is the load key when the global-load configuration bit is set: every device then accepts it.

After a hardware reset, and after a completed software reset, the block insists that the next accepted write is the calibration refresh key. Any other write before that refresh has no effect, and it raises a sticky sequence-error flag. The CRC-enable state of the serial link is also kept here and is forced back on by any reset.

All three action outputs are registered, one-cycle pulses in the system clock domain.

Top module: `kscc_top`

## Requirements
- R1: After the synchronous hardware reset `rst`, `reset_occurred` is 1, `seq_error` is 0, `crc_enable` is 1, all three pulse outputs are 0, and a calibration refresh is pending.
- R2: The refresh key 0xFCBA written to register 0x08 raises `refresh_pulse` in the cycle after the write. This applies when it is the first accepted write after a reset, and again whenever it is written later.
- R3: While a refresh is pending, every other accepted write has no effect: no pulse, no flag cleared, no CRC change. It also sets `seq_error` (bit 5 of the diagnostic register).
- R4: Key 0x15FA to register 0x08, followed by key 0xAF51 to register 0x08 as the very next accepted write, raises `soft_rst_pulse` in the cycle after the second write. That same edge sets `reset_occurred`, clears `seq_error`, sets `crc_enable`, and makes a refresh pending again.
- R5: An accepted write between the two reset keys aborts the sequence, and so does a wrong second key. The aborting write is otherwise handled as a normal write.
- R6: A write to diagnostic register 0x14 clears `reset_occurred` when data bit 13 is 1 and clears `seq_error` when data bit 5 is 1. A bit written as 0 leaves its flag unchanged.
- R7: The load key 0x1DAC written to register 0x07 with a matching device address raises `load_pulse` in the next cycle. Any other data value written to 0x07 does not.
- R8: When `global_load` is 1, the load key raises `load_pulse` whatever its device address. Any other write whose device address differs from `dev_pins` is ignored entirely and does not disturb a reset sequence in progress.
- R9: A write to configuration register 0x10 sets `crc_enable` to data bit 0. Any reset sets it back to 1.
- R10: Each pulse output is high for exactly one cycle per triggering write. At most one of the three pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | One-cycle strobe for a received register write |
| wr_dev | input | 2 | Device address field of the write |
| wr_reg | input | 5 | Register address of the write |
| wr_data | input | 16 | Data of the write |
| dev_pins | input | 2 | This device's strapped address |
| global_load | input | 1 | Load key accepted regardless of device address |
| soft_rst_pulse | output | 1 | One-cycle software reset strobe |
| refresh_pulse | output | 1 | One-cycle calibration refresh start strobe |
| load_pulse | output | 1 | One-cycle output latch load strobe |
| reset_occurred | output | 1 | Sticky reset-occurred flag (diagnostic bit 13) |
| seq_error | output | 1 | Sticky sequence-error flag (diagnostic bit 5) |
| crc_enable | output | 1 | CRC checking enable for the serial link |

## Verification
The assertions check the pulse properties on every cycle: the three pulses never overlap and none lasts two cycles. They also check what must precede a pulse: a soft reset pulse needs the second key in the previous cycle, and a load pulse needs the load key in the previous cycle. Finally, they check that the sticky flags only rise through a reset or a rejected write. The ordering rules need the bench's scenarios to show them. Those are the refresh gate that swallows early writes, aborting the reset sequence with an intervening or wrong key, W1C selectivity, and the device-address filtering that leaves a sequence intact.

// File: rtl/kscc_pkg.sv
package kscc_pkg;

  typedef enum logic [1:0] {
    ST_NEED_REFRESH = 2'd0,
    ST_IDLE         = 2'd1,
    ST_KEY1         = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic key1;
    logic key2;
    logic refresh;
    logic load;
    logic diag;
    logic cfg;
  } wr_class_t;

endpackage

// File: rtl/kscc_decode.sv
module kscc_decode #(
  parameter int DEV_W     = 2,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int KEY_ADDR  = 8,
  parameter int LOAD_ADDR = 7,
  parameter int DIAG_ADDR = 20,
  parameter int CFG_ADDR  = 16,
  parameter int KEY1_VAL  = 16'h15FA,
  parameter int KEY2_VAL  = 16'hAF51,
  parameter int REFR_VAL  = 16'hFCBA,
  parameter int LOAD_VAL  = 16'h1DAC
) (
  input  logic                  wr_en,
  input  logic [DEV_W-1:0]      wr_dev,
  input  logic [DEV_W-1:0]      dev_pins,
  input  logic [ADDR_W-1:0]     wr_reg,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  global_load,
  output logic                  accept,
  output kscc_pkg::wr_class_t   cls
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] LA = ADDR_W'(LOAD_ADDR);
  localparam logic [ADDR_W-1:0] DA = ADDR_W'(DIAG_ADDR);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CFG_ADDR);

  logic dev_match;
  logic on_key;

  always_comb begin
    dev_match   = (wr_dev == dev_pins);
    on_key      = (wr_reg == KA);
    cls.key1    = on_key && (wr_data == DATA_W'(KEY1_VAL));
    cls.key2    = on_key && (wr_data == DATA_W'(KEY2_VAL));
    cls.refresh = on_key && (wr_data == DATA_W'(REFR_VAL));
    cls.load    = (wr_reg == LA) && (wr_data == DATA_W'(LOAD_VAL));
    cls.diag    = (wr_reg == DA);
    cls.cfg     = (wr_reg == CA);
    accept      = wr_en && (dev_match || (global_load && cls.load));
  end
endmodule

// File: rtl/kscc_seq_fsm.sv
module kscc_seq_fsm (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  kscc_pkg::wr_class_t cls,
  output logic                go_reset,
  output logic                do_err,
  output logic                do_diag,
  output logic                do_cfg,
  output logic                soft_rst_pulse,
  output logic                refresh_pulse,
  output logic                load_pulse
);
  import kscc_pkg::*;

  seq_state_e state, nxt;
  logic go_ref, go_load, normal;

  always_comb begin
    nxt      = state;
    go_reset = 1'b0;
    go_ref   = 1'b0;
    go_load  = 1'b0;
    do_err   = 1'b0;
    do_diag  = 1'b0;
    do_cfg   = 1'b0;
    normal   = accept && ((state == ST_IDLE) ||
                          (state == ST_KEY1 && !cls.key2));
    if (accept && state == ST_NEED_REFRESH) begin
      if (cls.refresh) begin
        go_ref = 1'b1;
        nxt    = ST_IDLE;
      end else begin
        do_err = 1'b1;
      end
    end
    if (accept && state == ST_KEY1 && cls.key2) begin
      go_reset = 1'b1;
      nxt      = ST_NEED_REFRESH;
    end
    if (normal) begin
      nxt     = cls.key1 ? ST_KEY1 : ST_IDLE;
      go_ref  = cls.refresh;
      go_load = cls.load;
      do_diag = cls.diag;
      do_cfg  = cls.cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_NEED_REFRESH;
      soft_rst_pulse <= 1'b0;
      refresh_pulse  <= 1'b0;
      load_pulse     <= 1'b0;
    end else begin
      state          <= nxt;
      soft_rst_pulse <= go_reset;
      refresh_pulse  <= go_ref;
      load_pulse     <= go_load;
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({soft_rst_pulse, refresh_pulse, load_pulse})); // R10
  AST_SOFT_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |=> !soft_rst_pulse); // R10
  AST_REFRESH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |-> (state == ST_NEED_REFRESH)); // R4
endmodule

// File: rtl/kscc_diag_flags.sv
module kscc_diag_flags (
  input  logic clk,
  input  logic rst,
  input  logic go_reset,
  input  logic do_err,
  input  logic do_diag,
  input  logic clr_rst_bit,
  input  logic clr_err_bit,
  input  logic do_cfg,
  input  logic crc_bit,
  output logic reset_occurred,
  output logic seq_error,
  output logic crc_enable
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reset_occurred <= 1'b1;
      seq_error      <= 1'b0;
      crc_enable     <= 1'b1;
    end else if (go_reset) begin
      reset_occurred <= 1'b1;
      seq_error      <= 1'b0;
      crc_enable     <= 1'b1;
    end else begin
      if (do_err) seq_error <= 1'b1;
      if (do_diag && clr_rst_bit) reset_occurred <= 1'b0;
      if (do_diag && clr_err_bit) seq_error <= 1'b0;
      if (do_cfg) crc_enable <= crc_bit;
    end
  end

  AST_RSTFLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_occurred) |-> $past(go_reset)); // R4
  AST_SEQERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_error) |-> $past(do_err)); // R3
endmodule

// File: rtl/kscc_top.sv
module kscc_top #(
  parameter int DEV_W      = 2,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int KEY_ADDR   = 8,
  parameter int LOAD_ADDR  = 7,
  parameter int DIAG_ADDR  = 20,
  parameter int CFG_ADDR   = 16,
  parameter int KEY1_VAL   = 16'h15FA,
  parameter int KEY2_VAL   = 16'hAF51,
  parameter int REFR_VAL   = 16'hFCBA,
  parameter int LOAD_VAL   = 16'h1DAC,
  parameter int RSTOCC_BIT = 13,
  parameter int SEQERR_BIT = 5,
  parameter int CRC_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DEV_W-1:0]  wr_dev,
  input  logic [ADDR_W-1:0] wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DEV_W-1:0]  dev_pins,
  input  logic              global_load,
  output logic              soft_rst_pulse,
  output logic              refresh_pulse,
  output logic              load_pulse,
  output logic              reset_occurred,
  output logic              seq_error,
  output logic              crc_enable
);
  kscc_pkg::wr_class_t cls;
  logic accept, go_reset, do_err, do_diag, do_cfg;

  kscc_decode #(
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .LOAD_ADDR(LOAD_ADDR), .DIAG_ADDR(DIAG_ADDR),
    .CFG_ADDR(CFG_ADDR), .KEY1_VAL(KEY1_VAL), .KEY2_VAL(KEY2_VAL),
    .REFR_VAL(REFR_VAL), .LOAD_VAL(LOAD_VAL)
  ) u_dec (
    .wr_en(wr_en), .wr_dev(wr_dev), .dev_pins(dev_pins), .wr_reg(wr_reg),
    .wr_data(wr_data), .global_load(global_load), .accept(accept), .cls(cls)
  );

  kscc_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .accept(accept), .cls(cls),
    .go_reset(go_reset), .do_err(do_err), .do_diag(do_diag), .do_cfg(do_cfg),
    .soft_rst_pulse(soft_rst_pulse), .refresh_pulse(refresh_pulse),
    .load_pulse(load_pulse)
  );

  kscc_diag_flags u_flags (
    .clk(clk), .rst(rst), .go_reset(go_reset), .do_err(do_err),
    .do_diag(do_diag), .clr_rst_bit(wr_data[RSTOCC_BIT]),
    .clr_err_bit(wr_data[SEQERR_BIT]), .do_cfg(do_cfg),
    .crc_bit(wr_data[CRC_BIT]), .reset_occurred(reset_occurred),
    .seq_error(seq_error), .crc_enable(crc_enable)
  );

  AST_SOFT_RST_NEEDS_KEY2: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |-> $past(wr_en && wr_reg == ADDR_W'(KEY_ADDR) &&
                             wr_data == DATA_W'(KEY2_VAL))); // R4
  AST_LOAD_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> $past(wr_en && wr_reg == ADDR_W'(LOAD_ADDR) &&
                         wr_data == DATA_W'(LOAD_VAL))); // R7
  AST_CRC_BACK_ON: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |-> (crc_enable && reset_occurred)); // R9
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse); // R10
endmodule

// File: tb/tb_kscc_top.sv
module tb_kscc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0]  wr_dev = 2'b01;
  logic [4:0]  wr_reg = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  dev_pins = 2'b01;
  logic global_load = 1'b0;
  logic soft_rst_pulse, refresh_pulse, load_pulse;
  logic reset_occurred, seq_error, crc_enable;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kscc_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dev(wr_dev), .wr_reg(wr_reg),
    .wr_data(wr_data), .dev_pins(dev_pins), .global_load(global_load),
    .soft_rst_pulse(soft_rst_pulse), .refresh_pulse(refresh_pulse),
    .load_pulse(load_pulse), .reset_occurred(reset_occurred),
    .seq_error(seq_error), .crc_enable(crc_enable)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drives at a negedge, returns at the next negedge with results visible
  task automatic wr(input logic [1:0] dev, input logic [4:0] r,
                    input logic [15:0] d);
    wr_dev = dev; wr_reg = r; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [2:0] pulses();
    return {soft_rst_pulse, refresh_pulse, load_pulse};
  endfunction

  task automatic t_reset_state();
    check("R1", "reset_occurred", reset_occurred, 1);
    check("R1", "seq_error", seq_error, 0);
    check("R1", "crc_enable", crc_enable, 1);
    check("R1", "pulses", pulses(), 0);
  endtask

  task automatic t_refresh_gate();
    wr(2'b01, 5'h14, 16'h2000);
    check("R3", "diag before refresh ignored", reset_occurred, 1);
    check("R3", "seq_error set", seq_error, 1);
    wr(2'b01, 5'h07, 16'h1DAC);
    check("R3", "load before refresh", pulses(), 0);
    wr(2'b01, 5'h10, 16'h0000);
    check("R3", "cfg before refresh", crc_enable, 1);
    wr(2'b01, 5'h08, 16'hFCBA);
    check("R2", "refresh pulse", pulses(), 3'b010);
    @(negedge clk);
    check("R10", "refresh one cycle", pulses(), 0);
  endtask

  task automatic t_diag_w1c();
    wr(2'b01, 5'h14, 16'h2000);
    check("R6", "rst flag cleared", reset_occurred, 0);
    check("R6", "seq_error kept", seq_error, 1);
    wr(2'b01, 5'h14, 16'h0020);
    check("R6", "seq_error cleared", seq_error, 0);
  endtask

  task automatic t_load();
    wr(2'b01, 5'h07, 16'h1DAC);
    check("R7", "load match", pulses(), 3'b001);
    @(negedge clk);
    check("R10", "load one cycle", pulses(), 0);
    wr(2'b01, 5'h07, 16'h1DAD);
    check("R7", "wrong load data", pulses(), 0);
    wr(2'b10, 5'h07, 16'h1DAC);
    check("R8", "load other dev no global", pulses(), 0);
    global_load = 1'b1;
    wr(2'b10, 5'h07, 16'h1DAC);
    check("R8", "load other dev global", pulses(), 3'b001);
    global_load = 1'b0;
  endtask

  task automatic t_crc();
    wr(2'b01, 5'h10, 16'h005C);
    check("R9", "crc disabled", crc_enable, 0);
  endtask

  task automatic t_abort();
    wr(2'b01, 5'h08, 16'h15FA);
    wr(2'b01, 5'h14, 16'h0000);
    wr(2'b01, 5'h08, 16'hAF51);
    check("R5", "intervening write aborts", soft_rst_pulse, 0);
    wr(2'b01, 5'h08, 16'h15FA);
    wr(2'b01, 5'h08, 16'hAF50);
    check("R5", "wrong key2 aborts", soft_rst_pulse, 0);
    wr(2'b01, 5'h08, 16'h15FA);
    wr(2'b01, 5'h07, 16'h1DAC);
    check("R5", "aborting load still acts", pulses(), 3'b001);
    wr(2'b01, 5'h08, 16'hAF51);
    check("R5", "key2 after abort", soft_rst_pulse, 0);
    check("R5", "state unchanged", seq_error, 0);
  endtask

  task automatic t_soft_reset();
    wr(2'b01, 5'h08, 16'h15FA);
    wr(2'b11, 5'h14, 16'h0000);
    check("R8", "other-device write ignored", pulses(), 0);
    wr(2'b01, 5'h08, 16'hAF51);
    check("R4", "soft reset pulse", pulses(), 3'b100);
    check("R4", "reset_occurred set", reset_occurred, 1);
    check("R9", "crc back on", crc_enable, 1);
    @(negedge clk);
    check("R10", "soft reset one cycle", pulses(), 0);
    wr(2'b01, 5'h07, 16'h1DAC);
    check("R4", "refresh pending again", pulses(), 0);
    check("R3", "seq_error after soft reset", seq_error, 1);
    wr(2'b01, 5'h08, 16'hFCBA);
    check("R2", "refresh after soft reset", pulses(), 3'b010);
    wr(2'b01, 5'h08, 16'hFCBA);
    check("R2", "refresh again while idle", pulses(), 3'b010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_refresh_gate();
    t_diag_w1c();
    t_load();
    t_crc();
    t_abort();
    t_soft_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule